// File: doc/BRIEF.md
# Interrupt Cause and Summary Register Pair

This block holds the interrupt causes of a network controller. A status register latches one cause bit for each event pulse that arrives from the transmit and receive engines, the timer and the bus logic. A companion enable register, with the same bit layout, selects which causes take part in interrupt signalling. The host acknowledges causes by writing ones to the status register. Writing back a word it has just read clears exactly the causes that word reported, so one write acknowledges everything the host has seen.

Two summary bits in the status word are derived live rather than stored. The normal summary groups the enabled completion-type causes. The abnormal summary groups every other enabled cause. A single registered interrupt line follows the summaries that are enabled. The status word also shows three read-only 3-bit fields: the receive process state, the transmit process state and an error code. These fields are driven directly by the engines. The register port is a plain write strobe with a one-bit address (0 = status, 1 = enable) and a combinational read.

Top module: `irq_status_regs`

## Requirements
- R1: After reset, all cause bits and all enable bits are 0 and irq_o is 0.
- R2: A 1 on event_i at a cause position sets that status bit at the next clock edge. The bit then stays set until the host clears it. The cause positions are 0, 1, 2, 3, 5, 6, 7, 8, 9, 10, 11 and 13.
- R3: event_i bits at positions that are not causes (4, 12, 14 and 15 to 31) have no effect on the status word.
- R4: A write to address 0 clears every cause bit whose data bit is 1 and leaves the other cause bits unchanged. Writing back a status value just read clears all the causes it showed.
- R5: If a cause event and a host clear of the same bit happen in the same cycle, the bit stays set.
- R6: Status bit 16 (normal summary) is the OR of the status-and-enable bits at positions 0, 2, 6 and 10.
- R7: Status bit 15 (abnormal summary) is the OR of the status-and-enable bits at positions 1, 3, 5, 7, 8, 9, 11 and 13.
- R8: Status writes to bits 15 to 25 have no effect on the value read back.
- R9: A status read returns rx_state_i in bits 19:17, tx_state_i in bits 22:20 and err_code_i in bits 25:23. Bits 4, 12, 14 and 31:26 read as 0.
- R10: A write to address 1 stores the data into the enable bits at the cause positions and at 15 and 16. The other enable bits read as 0.
- R11: irq_o is registered. One cycle after ((status bit 16 and enable bit 16) or (status bit 15 and enable bit 15)) is true, irq_o is 1; otherwise it is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 32 | Single-cycle cause pulses, at status bit positions |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| rx_state_i | input | 3 | Receive process state, shown in the status word |
| tx_state_i | input | 3 | Transmit process state, shown in the status word |
| err_code_i | input | 3 | Error code, shown in the status word |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that gives the clear priority would lose that cause, and the bench would see the bit read back as 0. It also writes ones into the summary and field positions, which would corrupt the read-back word if those writes were stored. It sets every event bit, which would expose a design that latches the unused positions. Separate enable patterns for each summary group catch a cause assigned to the wrong group. Checking irq_o every cycle catches an interrupt line that is combinational, or that ignores the enable bits of the summaries.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned ABN_BIT  = 15;
  localparam int unsigned NORM_BIT = 16;
  localparam int unsigned RX_LSB   = 17;
  localparam int unsigned TX_LSB   = RX_LSB + FIELD_W;
  localparam int unsigned ERR_LSB  = TX_LSB + FIELD_W;

  localparam logic [REG_W-1:0] NORM_MASK = REG_W'(32'h0000_0445);
  localparam logic [REG_W-1:0] CAUSE_MASK = REG_W'(32'h0000_2FEF);
  localparam logic [REG_W-1:0] ABN_MASK = CAUSE_MASK & ~NORM_MASK;
  localparam logic [REG_W-1:0] SUM_MASK =
    (REG_W'(1) << ABN_BIT) | (REG_W'(1) << NORM_BIT);
  localparam logic [REG_W-1:0] EN_MASK = CAUSE_MASK | SUM_MASK;
endpackage

// File: rtl/cause_latch.sv
module cause_latch #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_v, clr_v, q_q;

  always_comb begin
    set_v = set_i & MASK;
    clr_v = clr_en_i ? (clr_i & MASK) : '0;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr_v) | set_v) & MASK;
  end

  assign q_o = q_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (MASK[i]) begin : g_cause
      AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_q[i]); // R5
      AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en_i && clr_i[i] && !set_i[i]) |=> !q_q[i]); // R4
      AST_CAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i[i] && !(clr_en_i && clr_i[i])) |=> $stable(q_q[i])); // R2
    end else begin : g_unused
      AST_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> !q_q[i]); // R3
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (wr_i) q_q <= wdata_i & MASK;
  end

  assign q_o = q_q;

  AST_EN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_q)); // R10
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] enable_i,
  output logic             norm_o,
  output logic             abn_o,
  output logic             irq_o
);
  logic [REG_W-1:0] active;
  logic             req, irq_q;

  always_comb begin
    active = status_i & enable_i;
    norm_o = |(active & NORM_MASK);
    abn_o  = |(active & ABN_MASK);
    req    = (norm_o & enable_i[NORM_BIT]) | (abn_o & enable_i[ABN_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= req;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(status_i & enable_i & NORM_MASK) && enable_i[NORM_BIT]) ||
     (|(status_i & enable_i & ABN_MASK) && enable_i[ABN_BIT])) |=> irq_o); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(enable_i[NORM_BIT] || enable_i[ABN_BIT])) |=> !irq_o); // R11
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_W-1:0]   event_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [FIELD_W-1:0] rx_state_i,
  input  logic [FIELD_W-1:0] tx_state_i,
  input  logic [FIELD_W-1:0] err_code_i,
  output logic               irq_o
);
  logic [REG_W-1:0] cause_q, enable_q, status_w;
  logic             norm, abn;
  logic             wr_stat, wr_en;

  assign wr_stat = wr_i & ~addr_i;
  assign wr_en   = wr_i &  addr_i;

  cause_latch #(.W(REG_W), .MASK(CAUSE_MASK)) u_cause (
    .clk_i, .rst_ni,
    .set_i(event_i), .clr_en_i(wr_stat), .clr_i(wdata_i), .q_o(cause_q)
  );

  enable_reg #(.W(REG_W), .MASK(EN_MASK)) u_enable (
    .clk_i, .rst_ni, .wr_i(wr_en), .wdata_i, .q_o(enable_q)
  );

  irq_summary u_sum (
    .clk_i, .rst_ni, .status_i(cause_q), .enable_i(enable_q),
    .norm_o(norm), .abn_o(abn), .irq_o
  );

  always_comb begin
    status_w = cause_q;
    status_w[ABN_BIT]  = abn;
    status_w[NORM_BIT] = norm;
    status_w[RX_LSB  +: FIELD_W] = rx_state_i;
    status_w[TX_LSB  +: FIELD_W] = tx_state_i;
    status_w[ERR_LSB +: FIELD_W] = err_code_i;
    rdata_o = addr_i ? enable_q : status_w;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(enable_q[NORM_BIT]) || $past(enable_q[ABN_BIT]))); // R11
endmodule

// File: tb/sim_irq_status_regs.sv
module sim_irq_status_regs;
  localparam logic [31:0] CAUSE = 32'h0000_2FEF;
  localparam logic [31:0] NORM  = 32'h0000_0445;
  localparam logic [31:0] ABN   = CAUSE & ~NORM;
  localparam logic [31:0] ENM   = CAUSE | 32'h0001_8000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ev = '0, wdata = '0, rdata;
  logic        wr = 1'b0, addr = 1'b0, irq;
  logic [2:0]  rx = '0, tx = '0, err = '0;

  int          n_checks = 0, n_err = 0;
  bit          done = 0;
  logic [31:0] st_m = '0, en_m = '0;
  logic        irq_m = 1'b0;

  always #4 clk = ~clk;

  irq_status_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_state_i(rx), .tx_state_i(tx),
    .err_code_i(err), .irq_o(irq)
  );

  function automatic logic norm_f(logic [31:0] s, logic [31:0] e);
    return |(s & e & NORM);
  endfunction
  function automatic logic abn_f(logic [31:0] s, logic [31:0] e);
    return |(s & e & ABN);
  endfunction
  function automatic logic [31:0] exp_rd(logic a);
    logic [31:0] v;
    if (a) return en_m;
    v = st_m;
    v[15] = abn_f(st_m, en_m);
    v[16] = norm_f(st_m, en_m);
    v[19:17] = rx; v[22:20] = tx; v[25:23] = err;
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic [31:0] e, logic w, logic a, logic [31:0] d);
    logic nxt;
    @(negedge clk);
    ev = e; wr = w; addr = a; wdata = d;
    nxt = (norm_f(st_m, en_m) & en_m[16]) | (abn_f(st_m, en_m) & en_m[15]);
    @(posedge clk); #1;
    if (w && !a) st_m = st_m & ~d;
    st_m = (st_m | e) & CAUSE;
    if (w && a) en_m = d & ENM;
    irq_m = nxt;
    check(tag, rdata, exp_rd(a));
    check("R11", {31'd0, irq}, {31'd0, irq_m});
  endtask

  task automatic idle(logic a);
    cycle("R2", '0, 1'b0, a, '0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    #20; rst_n = 1'b1;
    @(negedge clk);
    addr = 1'b0; #1; check("R1", rdata, 32'h0);
    addr = 1'b1; #1; check("R1", rdata, 32'h0);
    check("R1", {31'd0, irq}, 32'h0);

    cycle("R3", 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    check("R2", rdata, CAUSE);
    cycle("R4", '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check("R4", rdata, 32'h0);

    cycle("R6", 32'h40, 1'b1, 1'b1, 32'h0001_0040);
    idle(1'b0);
    check("R6", {31'd0, rdata[16]}, 32'h1);
    check("R11", {31'd0, irq}, 32'h1);
    cycle("R11", '0, 1'b1, 1'b1, 32'h0000_0040);
    idle(1'b0);
    check("R11", {31'd0, irq}, 32'h0);

    cycle("R7", 32'h2000, 1'b1, 1'b1, 32'h0000_A000);
    idle(1'b0);
    check("R7", rdata[16:15], 2'b01);
    check("R11", {31'd0, irq}, 32'h1);

    rb = exp_rd(1'b0);
    cycle("R8", '0, 1'b1, 1'b0, 32'h03FF_8000);
    check("R8", rdata, rb);

    cycle("R5", 32'h2000, 1'b1, 1'b0, 32'h0000_2040);
    check("R5", rdata[13] ? 32'h1 : 32'h0, 32'h1);
    check("R4", rdata[6] ? 32'h1 : 32'h0, 32'h0);

    cycle("R2", 32'h0000_0F0F, 1'b0, 1'b0, '0);
    rb = rdata;
    cycle("R4", '0, 1'b1, 1'b0, rb);
    check("R4", rdata & CAUSE, 32'h0);

    rx = 3'd5; tx = 3'd3; err = 3'd6;
    idle(1'b0);
    check("R9", rdata & 32'hFFFE_7FFF, 32'h0000_0000 | (32'd5 << 17) | (32'd3 << 20) | (32'd6 << 23));

    cycle("R10", '0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    check("R10", rdata, ENM);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] e, d;
      logic w, a;
      e = (k % 3 == 0) ? ($urandom & $urandom) : 32'h0;
      w = ($urandom % 4) == 0;
      a = ($urandom % 5) == 0;
      d = $urandom;
      if (k % 64 == 0) begin rx = 3'($urandom); tx = 3'($urandom); err = 3'($urandom); end
      cycle(a ? "R10" : "R4", e, w, a, d);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule